// File: doc/BRIEF.md
# Sixteen-Pin GPIO Block with Two Programmable Clock Pins

This block gives software sixteen general-purpose pins through a plain register port that completes every access in one cycle. Every pin has an output-enable bit and an output-data bit, and its input is read back through a two-flop synchroniser. The lower thirteen pins can also raise interrupts. Each of these pins has its own trigger type: one of two levels or one of three kinds of edge. Edge events are held in a status bit until software clears that bit by writing a 1 to it.

The two highest pins (14 and 15) act as ordinary I/O pins unless a clock-select bit turns them into clock outputs. Each clock pin has its own generator. The generator is a three-state machine with the states `CG_IDLE`, `CG_HIGH` and `CG_LOW`. The transitions are:

- `CG_IDLE` to `CG_HIGH`: taken on the first cycle the generator is enabled.
- `CG_HIGH` to `CG_LOW`: taken when the high count has been used up.
- `CG_LOW` to `CG_HIGH`: taken when the low count has been used up.
- Any state to `CG_IDLE`: taken whenever the select bit is off.

The high count and the low count are set by software, so the pin can produce any division of the block clock and any duty cycle. After reset, pin 15 already outputs the block clock divided by two, and pin 14 is an input.

Top module: `gpio_clkpin_ctrl`

## Requirements
- R1: After reset, every pin has output enable 0, except pin 15. Pin 15 is in clock mode with high count 1 and low count 1, so it toggles at half the block clock. The clock-select register (address 7) reads 2, and both timing registers (addresses 8 and 9) read 0x00010001.
- R2: For a pin that is not in clock mode, `pin_oe[i]` equals bit i of the direction register (address 0) and `pin_out[i]` equals bit i of the data register (address 1). A write to either register shows on the pins in the cycle after the write edge.
- R3: Address 2 returns `pin_in` through a two-flop synchroniser. A change on `pin_in` is visible in the read data after two rising clock edges and not after one.
- R4: Only pins 0 to 12 have interrupt logic. In the enable register (address 3), bits above 12 read back as 0 and have no effect.
- R5: The trigger type is 3 bits per pin. The codes are: 0 active-high, 1 active-low, 2 rising edge, 3 falling edge, 4 either edge, and 5 to 7 never trigger. Pins 0 to 9 use address 4, bits [3i+2:3i]. Pins 10 to 12 use address 5, bits [3(i-10)+2:3(i-10)].
- R6: For an edge type, an edge on the synchronised input sets bit i of the status register (address 6). The bit stays set until a 1 is written to bit i at address 6. Writing 0 has no effect, and a new edge in the same cycle as a clear wins over the clear.
- R7: For a level type, status bit i shows the live synchronised level match. For every pin, `irq[i]` equals status bit i AND enable bit i.
- R8: Address 7 bit 0 puts pin 14 in clock mode, and bit 1 does the same for pin 15. In clock mode the pin has output enable 1 and drives the generator output, and its direction and data bits are ignored.
- R9: Address 8 sets the timing for pin 14 and address 9 for pin 15. Bits [7:0] hold the high count and bits [23:16] hold the low count. The output is high for exactly the high count and low for exactly the low count, and a count of 0 acts as 1.
- R10: When clock mode is switched off, the pin returns to its direction and data bits on the next cycle. When clock mode is switched on, the output is low for one cycle (`CG_IDLE`) and then starts a high phase.
- R11: A new timing value takes effect at the next phase load, with no reset of the generator.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_addr | input | 4 | Register word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data for reg_addr |
| pin_in | input | 16 | Pad input values |
| pin_out | output | 16 | Pad output values |
| pin_oe | output | 16 | Pad output enables |
| irq | output | 13 | Per-pin interrupt lines, pins 0 to 12 |

## Verification
The assertions check on every cycle that:

- A running generator never holds a zero count.
- A disabled generator falls back to `CG_IDLE`.
- A high phase is held while its count is above one.
- A latched edge status survives until it is cleared.
- Direction writes reach the pins one cycle later.
- A clock-mode pin always drives.

Only the bench scenarios can show the trigger encodings, the write-one-to-clear ordering, the synchroniser latency, and the exact high-count and low-count ratios. The bench shows these by comparing the pins and interrupt lines on every clock against a behavioural model, and by counting high cycles over whole periods.

// File: rtl/gpio_cp_pkg.sv
package gpio_cp_pkg;

    typedef enum logic [1:0] {
        CG_IDLE = 2'd0,
        CG_HIGH = 2'd1,
        CG_LOW  = 2'd2
    } cg_state_e;

    localparam logic [2:0] TRIG_HIGH = 3'd0;
    localparam logic [2:0] TRIG_LOW  = 3'd1;
    localparam logic [2:0] TRIG_RISE = 3'd2;
    localparam logic [2:0] TRIG_FALL = 3'd3;
    localparam logic [2:0] TRIG_BOTH = 3'd4;

    localparam int ADDR_DIR   = 0;
    localparam int ADDR_DOUT  = 1;
    localparam int ADDR_DIN   = 2;
    localparam int ADDR_IEN   = 3;
    localparam int ADDR_TRIG0 = 4;
    localparam int ADDR_STAT  = 6;
    localparam int ADDR_CKSEL = 7;
    localparam int ADDR_CKT0  = 8;

endpackage

// File: rtl/gpio_cp_sync.sv
module gpio_cp_sync #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            q      <= '0;
        end else begin
            meta_q <= d;
            q      <= meta_q;
        end
    end
endmodule

// File: rtl/gpio_cp_irq_cell.sv
module gpio_cp_irq_cell
    import gpio_cp_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       lvl,
    input  logic [2:0] trig,
    input  logic       clr,
    output logic       status
);
    logic prev_q;
    logic lat_q;
    logic is_edge;
    logic ev;

    always_comb begin
        is_edge = 1'b0;
        ev      = 1'b0;
        status  = 1'b0;
        case (trig)
            TRIG_HIGH: status = lvl;
            TRIG_LOW:  status = ~lvl;
            TRIG_RISE: begin is_edge = 1'b1; ev = lvl & ~prev_q; end
            TRIG_FALL: begin is_edge = 1'b1; ev = ~lvl & prev_q; end
            TRIG_BOTH: begin is_edge = 1'b1; ev = lvl ^ prev_q;  end
            default:   status = 1'b0;
        endcase
        if (is_edge) status = lat_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= 1'b0;
            lat_q  <= 1'b0;
        end else begin
            prev_q <= lvl;
            if (ev)       lat_q <= 1'b1;
            else if (clr) lat_q <= 1'b0;
        end
    end

    // R6
    lat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lat_q && !clr) |=> lat_q);

    // R6
    ev_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ev && clr) |=> lat_q);
endmodule

// File: rtl/gpio_cp_clkgen.sv
module gpio_cp_clkgen
    import gpio_cp_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [CNT_W-1:0] hi_cnt,
    input  logic [CNT_W-1:0] lo_cnt,
    output logic             clk_o
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    cg_state_e        state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [CNT_W-1:0] hi_eff, lo_eff;

    assign hi_eff = (hi_cnt == '0) ? ONE : hi_cnt;
    assign lo_eff = (lo_cnt == '0) ? ONE : lo_cnt;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= CG_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        if (!en) begin
            state_d = CG_IDLE;
            cnt_d   = '0;
        end else begin
            unique case (state_q)
                CG_IDLE: begin
                    state_d = CG_HIGH;
                    cnt_d   = hi_eff;
                end
                CG_HIGH: begin
                    if (cnt_q <= ONE) begin
                        state_d = CG_LOW;
                        cnt_d   = lo_eff;
                    end else begin
                        cnt_d = cnt_q - ONE;
                    end
                end
                CG_LOW: begin
                    if (cnt_q <= ONE) begin
                        state_d = CG_HIGH;
                        cnt_d   = hi_eff;
                    end else begin
                        cnt_d = cnt_q - ONE;
                    end
                end
                default: begin
                    state_d = CG_IDLE;
                    cnt_d   = '0;
                end
            endcase
        end
    end

    // outputs
    always_comb begin
        clk_o = (state_q == CG_HIGH);
    end

    // R9
    cnt_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != CG_IDLE) |-> (cnt_q != '0));

    // R10
    idle_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (state_q == CG_IDLE));

    // R9
    hold_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && state_q == CG_HIGH && cnt_q > ONE) |=>
        (state_q == CG_HIGH && cnt_q == $past(cnt_q) - ONE));
endmodule

// File: rtl/gpio_clkpin_ctrl.sv
module gpio_clkpin_ctrl
    import gpio_cp_pkg::*;
#(
    parameter int NPIN  = 16,
    parameter int NIO   = 14,
    parameter int NIRQ  = 13,
    parameter int CNT_W = 8,
    parameter int AW    = 4,
    parameter int DW    = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            reg_wr,
    input  logic [AW-1:0]   reg_addr,
    input  logic [DW-1:0]   reg_wdata,
    output logic [DW-1:0]   reg_rdata,
    input  logic [NPIN-1:0] pin_in,
    output logic [NPIN-1:0] pin_out,
    output logic [NPIN-1:0] pin_oe,
    output logic [NIRQ-1:0] irq
);
    localparam int NCLK   = NPIN - NIO;
    localparam int TPW    = DW / 3;
    localparam int LO_LSB = DW / 2;

    logic [NPIN-1:0]  dir_q, dout_q, din_s;
    logic [NIRQ-1:0]  ien_q, stat, clr;
    logic [2:0]       trig_q [NIRQ];
    logic [NCLK-1:0]  cksel_q, gen_clk;
    logic [CNT_W-1:0] hi_q [NCLK];
    logic [CNT_W-1:0] lo_q [NCLK];
    logic             unused_wdata;

    assign unused_wdata = ^reg_wdata;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dir_q   <= '0;
            dout_q  <= '0;
            ien_q   <= '0;
            cksel_q <= NCLK'(1) << (NCLK - 1);
            for (int i = 0; i < NIRQ; i++) trig_q[i] <= TRIG_HIGH;
            for (int g = 0; g < NCLK; g++) begin
                hi_q[g] <= CNT_W'(1);
                lo_q[g] <= CNT_W'(1);
            end
        end else if (reg_wr) begin
            if (reg_addr == AW'(ADDR_DIR))   dir_q   <= reg_wdata[NPIN-1:0];
            if (reg_addr == AW'(ADDR_DOUT))  dout_q  <= reg_wdata[NPIN-1:0];
            if (reg_addr == AW'(ADDR_IEN))   ien_q   <= reg_wdata[NIRQ-1:0];
            if (reg_addr == AW'(ADDR_CKSEL)) cksel_q <= reg_wdata[NCLK-1:0];
            for (int i = 0; i < NIRQ; i++) begin
                if (reg_addr == AW'(ADDR_TRIG0 + i / TPW))
                    trig_q[i] <= reg_wdata[3*(i%TPW) +: 3];
            end
            for (int g = 0; g < NCLK; g++) begin
                if (reg_addr == AW'(ADDR_CKT0 + g)) begin
                    hi_q[g] <= reg_wdata[CNT_W-1:0];
                    lo_q[g] <= reg_wdata[LO_LSB +: CNT_W];
                end
            end
        end
    end

    gpio_cp_sync #(.W(NPIN)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pin_in),
        .q     (din_s)
    );

    assign clr = (reg_wr && reg_addr == AW'(ADDR_STAT)) ? reg_wdata[NIRQ-1:0] : '0;

    for (genvar i = 0; i < NIRQ; i++) begin : g_irq
        gpio_cp_irq_cell u_cell (
            .clk    (clk),
            .rst_n  (rst_n),
            .lvl    (din_s[i]),
            .trig   (trig_q[i]),
            .clr    (clr[i]),
            .status (stat[i])
        );
    end

    assign irq = stat & ien_q;

    for (genvar g = 0; g < NCLK; g++) begin : g_clk
        gpio_cp_clkgen #(.CNT_W(CNT_W)) u_cg (
            .clk    (clk),
            .rst_n  (rst_n),
            .en     (cksel_q[g]),
            .hi_cnt (hi_q[g]),
            .lo_cnt (lo_q[g]),
            .clk_o  (gen_clk[g])
        );

        // R8
        clk_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
            cksel_q[g] |-> pin_oe[NIO+g]);
    end

    always_comb begin
        pin_out = dout_q;
        pin_oe  = dir_q;
        for (int g = 0; g < NCLK; g++) begin
            if (cksel_q[g]) begin
                pin_out[NIO+g] = gen_clk[g];
                pin_oe[NIO+g]  = 1'b1;
            end
        end
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            AW'(ADDR_DIR):   reg_rdata = DW'(dir_q);
            AW'(ADDR_DOUT):  reg_rdata = DW'(dout_q);
            AW'(ADDR_DIN):   reg_rdata = DW'(din_s);
            AW'(ADDR_IEN):   reg_rdata = DW'(ien_q);
            AW'(ADDR_STAT):  reg_rdata = DW'(stat);
            AW'(ADDR_CKSEL): reg_rdata = DW'(cksel_q);
            default:         reg_rdata = '0;
        endcase
        for (int i = 0; i < NIRQ; i++) begin
            if (reg_addr == AW'(ADDR_TRIG0 + i / TPW))
                reg_rdata[3*(i%TPW) +: 3] = trig_q[i];
        end
        for (int g = 0; g < NCLK; g++) begin
            if (reg_addr == AW'(ADDR_CKT0 + g)) begin
                reg_rdata[CNT_W-1:0]       = hi_q[g];
                reg_rdata[LO_LSB +: CNT_W] = lo_q[g];
            end
        end
    end

    // R2
    dir_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == AW'(ADDR_DIR)) |=>
        (pin_oe[NIO-1:0] == $past(reg_wdata[NIO-1:0])));
endmodule

// File: tb/gpio_clkpin_ctrl_tb_top.sv
`timescale 1ns/1ps
module gpio_clkpin_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr = 1'b0;
    logic [3:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [15:0] pin_in = '0;
    logic [15:0] pin_out, pin_oe;
    logic [12:0] irq;

    int nchk = 0;
    int nerr = 0;
    bit done = 0;
    bit run = 0;

    always #10 clk = ~clk;

    gpio_clkpin_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr(wr), .reg_addr(addr),
        .reg_wdata(wdata), .reg_rdata(rdata), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
    );

    // behavioural reference model
    bit [15:0] m_dir, m_dout, s1, s2, pv;
    bit [12:0] m_ien, m_lat;
    int        m_trig [13];
    bit [1:0]  m_ck;
    int        m_hi [2], m_lo [2], m_ph [2], m_cnt [2];

    function automatic bit edge_ev(int t, bit cur, bit prv);
        case (t)
            2: return cur & !prv;
            3: return !cur & prv;
            4: return cur ^ prv;
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic [12:0] m_stat();
        logic [12:0] s;
        for (int i = 0; i < 13; i++) begin
            case (m_trig[i])
                0: s[i] = s2[i];
                1: s[i] = !s2[i];
                2, 3, 4: s[i] = m_lat[i];
                default: s[i] = 1'b0;
            endcase
        end
        return s;
    endfunction

    always @(posedge clk) begin
        int hi, lo;
        if (!rst_n) begin
            m_dir <= '0; m_dout <= '0; s1 <= '0; s2 <= '0; pv <= '0;
            m_ien <= '0; m_lat <= '0; m_ck <= 2'b10;
            for (int i = 0; i < 13; i++) m_trig[i] <= 0;
            for (int g = 0; g < 2; g++) begin
                m_hi[g] <= 1; m_lo[g] <= 1; m_ph[g] <= 0; m_cnt[g] <= 0;
            end
        end else begin
            s1 <= pin_in; s2 <= s1; pv <= s2;
            for (int i = 0; i < 13; i++) begin
                if (edge_ev(m_trig[i], s2[i], pv[i])) m_lat[i] <= 1'b1;
                else if (wr && addr == 6 && wdata[i]) m_lat[i] <= 1'b0;
            end
            for (int g = 0; g < 2; g++) begin
                hi = (m_hi[g] == 0) ? 1 : m_hi[g];
                lo = (m_lo[g] == 0) ? 1 : m_lo[g];
                if (!m_ck[g]) begin
                    m_ph[g] <= 0; m_cnt[g] <= 0;
                end else if (m_ph[g] == 0) begin
                    m_ph[g] <= 1; m_cnt[g] <= hi;
                end else if (m_cnt[g] <= 1) begin
                    m_ph[g] <= (m_ph[g] == 1) ? 2 : 1;
                    m_cnt[g] <= (m_ph[g] == 1) ? lo : hi;
                end else begin
                    m_cnt[g] <= m_cnt[g] - 1;
                end
            end
            if (wr) begin
                case (addr)
                    0: m_dir <= wdata[15:0];
                    1: m_dout <= wdata[15:0];
                    3: m_ien <= wdata[12:0];
                    7: m_ck <= wdata[1:0];
                    8, 9: begin
                        m_hi[addr-8] <= int'(wdata[7:0]);
                        m_lo[addr-8] <= int'(wdata[23:16]);
                    end
                    default: ;
                endcase
                for (int i = 0; i < 13; i++)
                    if (addr == 4 + i / 10) m_trig[i] <= int'(wdata[3*(i%10) +: 3]);
            end
        end
    end

    function automatic logic [15:0] exp_out();
        logic [15:0] v = m_dout;
        for (int g = 0; g < 2; g++) if (m_ck[g]) v[14+g] = (m_ph[g] == 1);
        return v;
    endfunction

    function automatic logic [15:0] exp_oe();
        logic [15:0] v = m_dir;
        for (int g = 0; g < 2; g++) if (m_ck[g]) v[14+g] = 1'b1;
        return v;
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && run) begin
            chk(pin_out === exp_out(), "R2/R8/R9/R10/R11 pin_out per-cycle", 32'(pin_out), 32'(exp_out()));
            chk(pin_oe === exp_oe(), "R2/R8 pin_oe per-cycle", 32'(pin_oe), 32'(exp_oe()));
            chk(irq === (m_stat() & m_ien), "R6/R7 irq per-cycle", 32'(irq), 32'(m_stat() & m_ien));
        end
    end

    task automatic wr_reg(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr = 1'b1;
        @(negedge clk);
        wr = 1'b0; wdata = '0;
    endtask

    task automatic rd_reg(input logic [3:0] a, output logic [31:0] v);
        @(negedge clk);
        addr = a;
        #1;
        v = rdata;
    endtask

    task automatic rd_chk(input logic [3:0] a, input logic [31:0] exp, input string tag);
        logic [31:0] v;
        rd_reg(a, v);
        chk(v === exp, tag, v, exp);
    endtask

    task automatic count_high(input int pin, input int cycles, output int n);
        n = 0;
        for (int k = 0; k < cycles; k++) begin
            @(negedge clk);
            if (pin_out[pin]) n++;
        end
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            nchk++; nerr++;
            $display("FAIL watchdog expired actual=running expected=done");
            summary();
            $finish;
        end
    end

    initial begin
        int n;
        logic [31:0] v;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        run = 1'b1;

        // R1 reset defaults
        rd_chk(4'd0, 32'h0, "R1 direction reset");
        rd_chk(4'd7, 32'h2, "R1 clock select reset");
        rd_chk(4'd8, 32'h00010001, "R1 pin14 timing reset");
        rd_chk(4'd9, 32'h00010001, "R1 pin15 timing reset");
        chk(pin_oe === 16'h8000, "R1 only pin15 drives", 32'(pin_oe), 32'h8000);
        count_high(15, 20, n);
        chk(n == 10, "R1 pin15 half-rate clock", n, 10);

        // R2 direction and data
        wr_reg(4'd0, 32'h3FFF);
        wr_reg(4'd1, 32'hA5A5);
        chk(pin_oe[13:0] === 14'h3FFF, "R2 oe follows direction", 32'(pin_oe[13:0]), 32'h3FFF);
        chk(pin_out[13:0] === 14'h25A5, "R2 out follows data", 32'(pin_out[13:0]), 32'h25A5);
        wr_reg(4'd0, 32'h4000);
        wr_reg(4'd1, 32'h4000);
        chk(pin_oe[14] === 1'b1 && pin_out[14] === 1'b1, "R2 pin14 as plain output",
            {pin_oe[14], pin_out[14]}, 32'h3);

        // R3 synchroniser latency
        @(negedge clk); pin_in = 16'h1234;
        rd_chk(4'd2, 32'h0, "R3 one edge not yet visible");
        rd_chk(4'd2, 32'h1234, "R3 visible after two edges");
        pin_in = '0;
        repeat (4) @(negedge clk);

        // R4 enable width
        wr_reg(4'd3, 32'hFFFF);
        rd_chk(4'd3, 32'h1FFF, "R4 enable bits above 12 read 0");
        wr_reg(4'd5, 32'hFFFF_FFFF);
        rd_chk(4'd5, 32'h1FF, "R4/R5 upper type word has 3 pins");

        // R5 type encoding
        wr_reg(4'd4, (0) | (1 << 3) | (2 << 6) | (3 << 9) | (4 << 12) | (5 << 15));
        wr_reg(4'd5, 32'h2);
        rd_chk(4'd4, (1 << 3) | (2 << 6) | (3 << 9) | (4 << 12) | (5 << 15), "R5 type readback");
        @(negedge clk); pin_in = 16'h043F;
        repeat (4) @(negedge clk);
        rd_chk(4'd6, 32'h0415, "R5/R6/R7 status after rise");
        pin_in = '0;
        repeat (4) @(negedge clk);
        rd_chk(4'd6, 32'h041E, "R5/R6/R7 status after fall");

        // R6 write-one-to-clear
        wr_reg(4'd6, 32'h0);
        rd_chk(4'd6, 32'h041E, "R6 writing 0 keeps latch");
        wr_reg(4'd6, 32'h4);
        rd_chk(4'd6, 32'h041A, "R6 clear bit 2 only");
        wr_reg(4'd6, 32'h041F);
        rd_chk(4'd6, 32'h0002, "R6/R7 edges cleared, level stays");
        chk(irq === 13'h0002, "R7 irq is status and enable", 32'(irq), 32'h2);
        wr_reg(4'd3, 32'h0);
        chk(irq === 13'h0, "R7 irq masked by enable", 32'(irq), 32'h0);

        // R8 / R9 clock mode
        wr_reg(4'd0, 32'h0);
        wr_reg(4'd1, 32'h0);
        wr_reg(4'd8, (2 << 16) | 3);
        wr_reg(4'd7, 32'h3);
        repeat (3) @(negedge clk);
        chk(pin_oe[15:14] === 2'b11, "R8 clock pins drive", 32'(pin_oe[15:14]), 32'h3);
        count_high(14, 50, n);
        chk(n == 30, "R9 high 3 low 2 ratio", n, 30);
        wr_reg(4'd9, 32'h0);
        repeat (4) @(negedge clk);
        count_high(15, 20, n);
        chk(n == 10, "R9 zero counts act as 1", n, 10);

        // R11 retime without reset
        wr_reg(4'd8, (1 << 16) | 4);
        repeat (8) @(negedge clk);
        count_high(14, 50, n);
        chk(n == 40, "R11 new timing high 4 low 1", n, 40);

        // R10 leave and re-enter clock mode
        wr_reg(4'd7, 32'h0);
        chk(pin_oe[15:14] === 2'b00 && pin_out[15:14] === 2'b00, "R10 back to direction and data",
            {pin_oe[15:14], pin_out[15:14]}, 32'h0);
        wr_reg(4'd7, 32'h1);
        chk(pin_oe[14] === 1'b1 && pin_out[14] === 1'b0, "R10 idle cycle after enable",
            {pin_oe[14], pin_out[14]}, 32'h2);
        @(negedge clk);
        chk(pin_out[14] === 1'b1, "R10 high phase follows", 32'(pin_out[14]), 32'h1);

        repeat (10) @(negedge clk);
        done = 1;
        summary();
        $finish;
    end
endmodule